// File: doc/BRIEF.md
# Interrupt-Capable GPIO Pin Bank

This block is a bank of up to 32 general-purpose pins behind a small 32-bit register port. Every pin owns one configuration word. That word enables the pin's input path, its output, its output driver and its interrupt, and it selects one of five trigger conditions: a high level, a low level, a rising edge, a falling edge, or either edge. Three shared words are one bit per pin. They hold the synchronized input values, the output data, and a pending-interrupt status that software clears by writing ones.

Pad inputs pass through a two-stage synchronizer before anything else sees them. An edge is found by comparing the current synchronized sample with the one from the cycle before. A pin drives its pad only when both its output-enable bit and its driver-enable bit are set. The pin's interrupt line is its pending bit gated by its interrupt enable. Software takes a pin to be an input whenever that pin's input-enable bit is set.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every register reads zero, every pad output-enable is low and every interrupt line is low.
- R2: Pin i's configuration word is at byte address 4*i. Bit 0 is output enable, bit 1 is input enable, bit 2 is driver enable, bit 3 is interrupt enable, and bits 7:5 are the trigger code. Bit 4 and bits 31:8 read as zero. The stored bits read back as written.
- R3: pad_oe[i] is high only when bit 0 and bit 2 of pin i's configuration are both set. In that case pad_out[i] equals output-data bit i. Otherwise pad_out[i] is low.
- R4: The output-data word at 0x88 is read/write, one bit per pin.
- R5: The input word at 0x84 shows pad_in two rising clock edges after the pad changes.
- R6: With trigger code 000 (level high) or 001 (level low), the pending bit is set on every cycle in which the synchronized pin level matches the selected level.
- R7: Trigger code 010 sets the pending bit once for each synchronized 0-to-1 change. Trigger code 011 sets it once for each 1-to-0 change. A level that does not change sets nothing further.
- R8: Trigger code 100 sets the pending bit on either change. Codes 101, 110 and 111 never set it.
- R9: A pending bit is set only while both the interrupt-enable bit and the input-enable bit of that pin are set.
- R10: Writing a 1 to a bit of the status word at 0x80 clears that bit. Writing a 0 leaves the bit unchanged. A trigger condition that is true in the same cycle keeps the bit set, so an active level sets it again.
- R11: irq[i] is the pending bit gated by pin i's interrupt enable. Clearing the enable lowers irq[i] but keeps the pending bit.
- R12: The following all read zero, and writes to them change nothing: configuration words of pins at or above N_PINS, unmapped addresses, addresses that are not word-aligned, and status, output or input bits at or above N_PINS.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register port select; read data is zero when low |
| bus_en | input | 1 | Access enable; a write takes effect at the clock edge when sel, en and wr are all high |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| pad_in | input | N_PINS | Raw pad input levels |
| pad_out | output | N_PINS | Pad output data |
| pad_oe | output | N_PINS | Pad output-enable |
| irq | output | N_PINS | Per-pin interrupt lines |

## Verification
Faults in the synchronizer or the previous-sample register show up as an input word that changes one edge early or late. They also show up as a pending bit that edge triggers set twice, or never set. Both can be seen within three cycles of a pad change. A wrong clear path shows on the next status read: a bit survives a one-write, or a zero-write drops it. A configuration bit that is decoded at the wrong position shows at once, either on pad_oe and pad_out or as a trigger that fires for the wrong polarity. The bench runs a behavioural model beside the block and compares read data, pad drive and interrupt lines on every clock. Any such fault is therefore caught in the cycle it first becomes visible.

// File: rtl/gpio_bank_pkg.sv
// Shared types and address constants for the GPIO pin bank.
// Assumes an 8-bit byte address space with 32-bit words.
package gpio_bank_pkg;

    // Trigger condition codes held in configuration bits 7:5
    typedef enum logic [2:0] {
        TRIG_LVL_HI = 3'b000,
        TRIG_LVL_LO = 3'b001,
        TRIG_RISE   = 3'b010,
        TRIG_FALL   = 3'b011,
        TRIG_ANY    = 3'b100
    } trig_e;

    // Stored per-pin configuration
    typedef struct packed {
        logic [2:0] trig;
        logic       irq_en;
        logic       drv_en;
        logic       in_en;
        logic       out_en;
    } pin_cfg_t;

    localparam logic [7:0] ADDR_STAT = 8'h80;
    localparam logic [7:0] ADDR_INP  = 8'h84;
    localparam logic [7:0] ADDR_OUT  = 8'h88;

    // Unpack the low byte of a configuration write
    function automatic pin_cfg_t cfg_from_byte(input logic [7:0] b);
        pin_cfg_t c;
        c.out_en = b[0];
        c.in_en  = b[1];
        c.drv_en = b[2];
        c.irq_en = b[3];
        c.trig   = b[7:5];
        return c;
    endfunction

    // Pack a configuration back into its read layout (bit 4 reads zero)
    function automatic logic [7:0] cfg_to_byte(input pin_cfg_t c);
        return {c.trig, 1'b0, c.irq_en, c.drv_en, c.in_en, c.out_en};
    endfunction

endpackage

// File: rtl/gpio_bank_sync.sv
// Two-flop synchronizer with one extra history stage per bit.
// cur is the synchronized level, prev the same level one cycle older.
// Assumes pad_in is asynchronous to clk; all stages reset to zero.
module gpio_bank_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);
    logic [W-1:0] stage1;

    // Shift pad levels through two sync flops and one history flop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            cur    <= '0;
            prev   <= '0;
        end else begin
            stage1 <= d;
            cur    <= stage1;
            prev   <= cur;
        end
    end
endmodule

// File: rtl/gpio_bank_trig.sv
// Per-pin trigger detector: purely combinational.
// hit is high in a cycle whose sampled levels meet the selected condition
// and the pin is armed. Codes outside the defined set never hit.
module gpio_bank_trig
    import gpio_bank_pkg::*;
(
    input  logic [2:0] mode,
    input  logic       arm,
    input  logic       cur,
    input  logic       prev,
    output logic       hit
);
    logic cond;

    // Select the trigger condition from the mode code
    always_comb begin
        case (trig_e'(mode))
            TRIG_LVL_HI: cond = cur;
            TRIG_LVL_LO: cond = ~cur;
            TRIG_RISE:   cond = cur & ~prev;
            TRIG_FALL:   cond = ~cur & prev;
            TRIG_ANY:    cond = cur ^ prev;
            default:     cond = 1'b0;
        endcase
    end

    assign hit = arm & cond;
endmodule

// File: rtl/gpio_irq_bank.sv
// Register-mapped GPIO bank with per-pin configuration and interrupts.
// Word 4*i: pin i config; 0x80 pending status (write-one-to-clear);
// 0x84 synchronized inputs; 0x88 output data. Misaligned, unmapped and
// unimplemented addresses read zero and ignore writes. Assumes N_PINS <= 32.
module gpio_irq_bank
    import gpio_bank_pkg::*;
#(
    parameter int N_PINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_en,
    input  logic              bus_wr,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [N_PINS-1:0] pad_in,
    output logic [N_PINS-1:0] pad_out,
    output logic [N_PINS-1:0] pad_oe,
    output logic [N_PINS-1:0] irq
);
    localparam int WORD_W = 32;
    localparam int IDX_W  = (N_PINS > 1) ? $clog2(N_PINS) : 1;

    logic              wr_fire;
    logic              cfg_space;
    logic [5:0]        word_no;
    logic [IDX_W-1:0]  word_idx;
    logic [N_PINS-1:0] smp_cur, smp_prev;
    logic [N_PINS-1:0] hit_vec, arm_vec;
    logic [N_PINS-1:0] stat_q, odata_q, clr_mask;
    logic [N_PINS*8-1:0] cfg_flat;

    assign wr_fire   = bus_sel & bus_en & bus_wr;
    assign word_no   = bus_addr[7:2];
    assign word_idx  = bus_addr[2 +: IDX_W];
    assign cfg_space = (bus_addr[1:0] == 2'b00) && (word_no < 6'(N_PINS));

    gpio_bank_sync #(.W(N_PINS)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (pad_in),
        .cur  (smp_cur),
        .prev (smp_prev)
    );

    for (genvar i = 0; i < N_PINS; i++) begin : g_pin
        pin_cfg_t cfg_q;

        // Capture a configuration write aimed at this pin
        always_ff @(posedge clk) begin
            if (!rst_n)
                cfg_q <= '0;
            else if (wr_fire && cfg_space && word_no == 6'(i))
                cfg_q <= cfg_from_byte(bus_wdata[7:0]);
        end

        assign cfg_flat[i*8 +: 8] = cfg_to_byte(cfg_q);
        assign arm_vec[i] = cfg_q.irq_en & cfg_q.in_en;

        gpio_bank_trig u_trig (
            .mode(cfg_q.trig),
            .arm (arm_vec[i]),
            .cur (smp_cur[i]),
            .prev(smp_prev[i]),
            .hit (hit_vec[i])
        );

        assign pad_oe[i]  = cfg_q.out_en & cfg_q.drv_en;
        assign pad_out[i] = pad_oe[i] & odata_q[i];
        assign irq[i]     = stat_q[i] & cfg_q.irq_en;
    end

    assign clr_mask = (wr_fire && bus_addr == ADDR_STAT) ? bus_wdata[N_PINS-1:0] : '0;

    // Pending status: new hits win over a same-cycle clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            stat_q <= '0;
        else
            stat_q <= (stat_q & ~clr_mask) | hit_vec;
    end

    // Output data register
    always_ff @(posedge clk) begin
        if (!rst_n)
            odata_q <= '0;
        else if (wr_fire && bus_addr == ADDR_OUT)
            odata_q <= bus_wdata[N_PINS-1:0];
    end

    // Combinational read mux; zero for anything not mapped
    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            if (cfg_space)
                bus_rdata = WORD_W'(cfg_flat[word_idx*8 +: 8]);
            else if (bus_addr == ADDR_STAT)
                bus_rdata = WORD_W'(stat_q);
            else if (bus_addr == ADDR_INP)
                bus_rdata = WORD_W'(smp_cur);
            else if (bus_addr == ADDR_OUT)
                bus_rdata = WORD_W'(odata_q);
        end
    end
endmodule

// File: rtl/gpio_irq_bank_chk.sv
// Assertion checker for gpio_irq_bank, attached by bind below.
// Watches ports plus the synchronizer output, trigger hits, arm vector
// and pending register, each driven by separate logic in the block.
module gpio_irq_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int N_PINS = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_en,
    input logic              bus_wr,
    input logic [7:0]        bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [N_PINS-1:0] pad_in,
    input logic [N_PINS-1:0] pad_out,
    input logic [N_PINS-1:0] pad_oe,
    input logic [N_PINS-1:0] stat,
    input logic [N_PINS-1:0] hit,
    input logic [N_PINS-1:0] arm,
    input logic [N_PINS-1:0] smp_cur
);
    logic [1:0] since_rst;
    logic       clr_wr;

    // Count cycles since reset, saturating, to guard $past look-backs
    always_ff @(posedge clk) begin
        if (!rst_n)
            since_rst <= 2'd0;
        else if (since_rst != 2'd3)
            since_rst <= since_rst + 2'd1;
    end

    assign clr_wr = bus_sel & bus_en & bus_wr & (bus_addr == ADDR_STAT);

    a_r3_out_needs_oe: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_out & ~pad_oe) == '0);

    a_r5_sync_lag: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2) |-> (smp_cur == $past(pad_in, 2)));

    a_r9_set_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd1) |-> ((stat & ~$past(stat) & ~$past(arm)) == '0));

    a_r10_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd1 && $past(clr_wr)) |->
        ((stat & $past(bus_wdata[N_PINS-1:0]) & ~$past(hit)) == '0));
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.N_PINS(N_PINS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_en   (bus_en),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .pad_in   (pad_in),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe),
    .stat     (stat_q),
    .hit      (hit_vec),
    .arm      (arm_vec),
    .smp_cur  (smp_cur)
);

// File: tb/sim_gpio_irq_bank.sv
`timescale 1ns/1ps
module sim_gpio_irq_bank;
    localparam int NP = 24;
    localparam bit [31:0] PMASK = (32'd1 << NP) - 32'd1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0, bus_en = 1'b0, bus_wr = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_out, pad_oe, irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    gpio_irq_bank #(.N_PINS(NP)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_en(bus_en),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .irq(irq)
    );

    // ---------------- behavioural reference model ----------------
    bit [31:0] m_s1, m_s2, m_prev, m_stat, m_out;
    bit [31:0] m_cfg [32];

    function automatic bit m_cond(int i);
        bit [31:0] c = m_cfg[i];
        if (!(c[3] && c[1])) return 1'b0;
        case ((c >> 5) & 32'd7)
            0: return m_s2[i];
            1: return !m_s2[i];
            2: return m_s2[i] && !m_prev[i];
            3: return !m_s2[i] && m_prev[i];
            4: return m_s2[i] != m_prev[i];
            default: return 1'b0;
        endcase
    endfunction

    function automatic bit [31:0] m_read(logic sel, logic [7:0] a);
        int w;
        if (!sel || a[1:0] != 2'b00) return 32'd0;
        w = int'(a) / 4;
        if (w < NP) return m_cfg[w];
        if (w == 32) return m_stat;
        if (w == 33) return m_s2 & PMASK;
        if (w == 34) return m_out;
        return 32'd0;
    endfunction

    always @(posedge clk) begin
        bit [31:0] n_stat;
        bit [31:0] clr;
        bit wr;
        int w;
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_prev = 0; m_stat = 0; m_out = 0;
            for (int i = 0; i < 32; i++) m_cfg[i] = 0;
        end else begin
            wr = bus_sel && bus_en && bus_wr;
            clr = (wr && bus_addr == 8'h80) ? (bus_wdata & PMASK) : 32'd0;
            n_stat = m_stat & ~clr;
            for (int i = 0; i < NP; i++)
                if (m_cond(i)) n_stat[i] = 1'b1;
            m_stat = n_stat;
            w = int'(bus_addr) / 4;
            if (wr && bus_addr[1:0] == 2'b00 && w < NP)
                m_cfg[w] = bus_wdata & 32'h0000_00EF;
            if (wr && bus_addr == 8'h88)
                m_out = bus_wdata & PMASK;
            m_prev = m_s2;
            m_s2 = m_s1;
            m_s1 = 32'(pad_in);
        end
    end

    // ---------------- check helpers ----------------
    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Per-clock comparison against the model, away from the edge
    always @(posedge clk) begin
        bit [31:0] e_oe, e_out, e_irq;
        #5;
        if (rst_n && !done) begin
            e_oe = 0; e_out = 0; e_irq = 0;
            for (int i = 0; i < NP; i++) begin
                e_oe[i]  = m_cfg[i][0] & m_cfg[i][2];
                e_out[i] = e_oe[i] & m_out[i];
                e_irq[i] = m_stat[i] & m_cfg[i][3];
            end
            chk("model rdata R2 R4 R12", bus_rdata, m_read(bus_sel, bus_addr));
            chk("model pad_oe R3", 32'(pad_oe), e_oe);
            chk("model pad_out R3", 32'(pad_out), e_out);
            chk("model irq R11", 32'(irq), e_irq);
        end
    end

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_en = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #5;
        d = bus_rdata;
        bus_sel = 1'b0; bus_en = 1'b0;
    endtask

    task automatic rd_chk(string tag, logic [7:0] a, logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    // ---------------- directed sequence ----------------
    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_chk("R1 cfg0", 8'h00, 0);
        rd_chk("R1 status", 8'h80, 0);
        rd_chk("R1 input", 8'h84, 0);
        rd_chk("R1 outdata", 8'h88, 0);
        chk("R1 pad_oe", 32'(pad_oe), 0);
        chk("R1 irq", 32'(irq), 0);

        // R2 config layout, bit 4 reads zero
        wr(8'h04, 32'hFFFF_FFFF);
        rd_chk("R2 cfg1 readback", 8'h04, 32'h0000_00EF);
        wr(8'h04, 0);

        // R3 / R4 pad drive and output data
        wr(8'h08, 32'h05);
        wr(8'h88, 32'h04);
        chk("R3 oe both set", 32'(pad_oe[2]), 1);
        chk("R3 out follows data", 32'(pad_out[2]), 1);
        wr(8'h08, 32'h01);
        chk("R3 oe without driver", 32'(pad_oe[2]), 0);
        chk("R3 out low without driver", 32'(pad_out[2]), 0);
        wr(8'h08, 32'h04);
        chk("R3 oe driver only", 32'(pad_oe[2]), 0);
        rd_chk("R4 outdata", 8'h88, 32'h04);
        wr(8'h88, 32'hFFFF_FFFF);
        rd_chk("R4 R12 outdata width", 8'h88, PMASK);

        // R5 synchronizer latency
        @(negedge clk); pad_in[5] = 1'b1;
        rd_chk("R5 after one edge", 8'h84, 0);
        rd_chk("R5 after two edges", 8'h84, 32'h20);

        // R9 interrupt without input enable, then R6 level high
        wr(8'h14, 32'h08);
        idle(3);
        rd_chk("R9 no set without input enable", 8'h80, 0);
        wr(8'h14, 32'h0A);
        rd_chk("R6 level high sets", 8'h80, 32'h20);
        chk("R11 irq raised", 32'(irq[5]), 1);
        wr(8'h80, 32'h20);
        rd_chk("R10 active level re-sets", 8'h80, 32'h20);
        @(negedge clk); pad_in[5] = 1'b0;
        idle(4);
        wr(8'h80, 32'h20);
        rd_chk("R10 clear", 8'h80, 0);

        // R11 masking keeps pending bit
        @(negedge clk); pad_in[5] = 1'b1;
        idle(4);
        wr(8'h14, 32'h02);
        rd_chk("R11 pending kept", 8'h80, 32'h20);
        chk("R11 irq masked", 32'(irq[5]), 0);
        wr(8'h80, 32'h20);
        @(negedge clk); pad_in[5] = 1'b0;

        // R6 level low on pin 6
        wr(8'h18, 32'h2A);
        rd_chk("R6 level low sets", 8'h80, 32'h40);
        wr(8'h18, 32'h22);
        wr(8'h80, 32'h40);
        rd_chk("R6 cleared", 8'h80, 0);

        // R7 rising edge on pin 7, R10 zero write
        wr(8'h1C, 32'h4A);
        idle(3);
        rd_chk("R7 no edge yet", 8'h80, 0);
        @(negedge clk); pad_in[7] = 1'b1;
        idle(3);
        rd_chk("R7 rising sets", 8'h80, 32'h80);
        wr(8'h80, 32'h0);
        rd_chk("R10 zero write keeps", 8'h80, 32'h80);
        wr(8'h80, 32'h80);
        idle(3);
        rd_chk("R7 once per edge", 8'h80, 0);

        // R7 falling edge on pin 8
        @(negedge clk); pad_in[8] = 1'b1;
        idle(3);
        wr(8'h20, 32'h6A);
        idle(3);
        rd_chk("R7 falling ignores high", 8'h80, 0);
        @(negedge clk); pad_in[8] = 1'b0;
        idle(3);
        rd_chk("R7 falling sets", 8'h80, 32'h100);
        wr(8'h80, 32'h100);
        wr(8'h20, 0);

        // R8 both edges on pin 9
        wr(8'h24, 32'h8A);
        @(negedge clk); pad_in[9] = 1'b1;
        idle(3);
        rd_chk("R8 both rising", 8'h80, 32'h200);
        wr(8'h80, 32'h200);
        rd_chk("R8 cleared", 8'h80, 0);
        @(negedge clk); pad_in[9] = 1'b0;
        idle(3);
        rd_chk("R8 both falling", 8'h80, 32'h200);
        wr(8'h80, 32'h200);

        // R8 undefined code 101 on pin 10
        wr(8'h28, 32'hAA);
        rd_chk("R2 cfg10 readback", 8'h28, 32'hAA);
        @(negedge clk); pad_in[10] = 1'b1;
        idle(3);
        @(negedge clk); pad_in[10] = 1'b0;
        idle(3);
        rd_chk("R8 undefined code silent", 8'h80, 0);

        // R12 unimplemented, unmapped and misaligned
        wr(8'h78, 32'hFF);
        rd_chk("R12 unimplemented pin cfg", 8'h78, 0);
        rd_chk("R12 unmapped read", 8'h90, 0);
        wr(8'h88, 32'h10);
        wr(8'h8A, 32'hFFFF);
        rd_chk("R12 misaligned write ignored", 8'h88, 32'h10);
        rd_chk("R12 misaligned read", 8'h89, 0);
        wr(8'h8C, 32'hFFFF_FFFF);
        rd_chk("R12 unmapped write ignored", 8'h88, 32'h10);

        idle(2);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule